// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the slave side of a four-wire serial port in front of a small byte-addressed memory and a one-byte status register. A host pulls the active-low select line down, clocks an eight-bit command in on the data input (most significant bit first), and then either streams address and data bytes in or receives data bytes back on the serial output. The serial output has a separate enable, so the pad can be left undriven whenever the block is not returning read data.

All pins are sampled with a fast system clock through a short synchronizer. Serial clock edges are found by comparing consecutive samples. Because of this, the serial clock may pause at any point with no loss of state. Two extra pins shape each transaction. A low level on the hold pin freezes the transfer at the current bit and releases the output. A low level on the protect pin, together with a lock bit kept in the status register, stops status writes.

Accesses to memory advance the address by one after each byte, and the address wraps at the top of the array. A byte cut short by deselection is dropped.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset the output enable is low, every memory byte reads 0x00 and the status byte reads 0x00.
- R2: While select is high, clock and data activity has no effect on state and the output enable stays low.
- R3: Only the first byte after a select falling edge is taken as a command, clocked in MSB first on rising serial clock edges. The commands are: 0x06 sets the write latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads memory and 0x02 writes memory. A command byte sent later in the same frame is treated as data.
- R4: After 0x03 and two address bytes (high byte first), memory bytes are returned MSB first. Each output bit changes only on a falling serial clock edge. The output enable rises on the first falling edge after the last address bit and stays high until select rises.
- R5: After 0x02 and two address bytes, each complete data byte is stored, but only if the write latch is set. If the latch is clear, the memory is not changed.
- R6: The 16-bit address is taken modulo the array depth. It increments after every read or written byte and wraps from the last location to 0.
- R7: The write latch is reported in status bit 1. It is cleared when select rises after a write or status-write frame in which at least one data byte was completed.
- R8: The status byte contains the lock bit in bit 7, two spare writable bits in bits 3:2 and the latch in bit 1. All other bits read 0. 0x05 returns this byte repeatedly until select rises, and 0x01 updates bits 7, 3 and 2 from its first data byte.
- R9: A status write is blocked when the protect pin is low and the lock bit is 1. The latch is still cleared at the end of the frame.
- R10: While hold is low, serial clock and select transitions are ignored and the output enable is low. When hold goes high, the transfer resumes at the same bit.
- R11: The hold pin is only taken in while the serial clock is low. A hold pulse that starts and ends while the serial clock is high has no effect.
- R12: If select rises partway through a byte, that byte is discarded. Bytes completed earlier in the same frame are kept.
- R13: An unknown command makes the rest of the frame ignored, and the output stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Active-low select; a falling edge starts a frame |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data input, taken on rising serial clock edges |
| holdn | input | 1 | Active-low hold that pauses the transfer |
| wpn | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data output |
| so_en | output | 1 | Output enable for the serial data pad |

## Verification
Hold and serial clock can change together. A hold request that arrives at the same moment as a falling clock edge must still let that edge shift the output, and hold must then freeze the bit counter. The bench lowers hold on the same system cycle as a falling clock edge in the middle of a read byte, then toggles clock and select while held. It judges the result by whether the reassembled byte and the byte after it match the model. A second case pulses hold entirely inside a clock-high phase of a write byte, and the stored value must come out unchanged.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_AHI, PH_ALO, PH_WDAT, PH_RDAT, PH_SRRD, PH_SRWR, PH_SKIP
  } phase_t;

  function automatic logic [15:0] addr_fold(input logic [15:0] a, input int unsigned depth);
    return 16'(32'(a) % depth);
  endfunction

  function automatic logic [15:0] addr_step(input logic [15:0] a, input int unsigned depth);
    return ((32'(a) + 32'd1) >= depth) ? 16'd0 : a + 16'd1;
  endfunction

  function automatic logic [7:0] sr_pack(input logic lock, input logic [1:0] spare, input logic wel);
    return {lock, 3'b000, spare, wel, 1'b0};
  endfunction

  function automatic logic sr_locked(input logic wpn, input logic lock);
    return !wpn && lock;
  endfunction

  function automatic phase_t phase_for_op(input logic [7:0] op);
    phase_t p;
    case (op)
      OP_READ, OP_WRITE: p = PH_AHI;
      OP_RDSR:           p = PH_SRRD;
      OP_WRSR:           p = PH_SRWR;
      default:           p = PH_SKIP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= RST_VAL;
        else        q <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= RST_VAL;
        else        q <= g_st[g-1].q;
    end
  end

  assign d_out = g_st[STAGES-1].q;

endmodule

// File: rtl/spim_pinctl.sv
module spim_pinctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic csn_s,
  input  logic holdn_s,
  output logic held,
  output logic csn_eff,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_csfall,
  output logic ev_csrise
);

  logic sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      held     <= 1'b0;
      csn_eff  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      if (!sck_s) held <= !holdn_s;
      if (!held)  csn_eff <= csn_s;
    end
  end

  assign ev_rise   = !held && !csn_eff &&  sck_s && !sck_prev;
  assign ev_fall   = !held && !csn_eff && !sck_s &&  sck_prev;
  assign ev_csfall = !held &&  csn_eff && !csn_s;
  assign ev_csrise = !held && !csn_eff &&  csn_s;

  // R11: hold state may only change when the sampled clock was low
  a_r11_hold_only_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> !$past(sck_s));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       held,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic       ev_frame,
  input  logic       si_s,
  input  logic       tx_active,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       so_bit,
  output logic       oe_q
);

  logic [2:0] bit_idx;
  logic [6:0] in_sr;
  logic [7:0] out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
      oe_q    <= 1'b0;
    end else if (ev_frame) begin
      bit_idx <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (ev_rise) begin
        in_sr   <= {in_sr[5:0], si_s};
        bit_idx <= bit_idx + 3'd1;
      end
      if (ev_fall && tx_active) begin
        out_sr <= (bit_idx == 3'd0) ? tx_byte : {out_sr[6:0], 1'b0};
        oe_q   <= 1'b1;
      end
    end
  end

  assign byte_done = ev_rise && (bit_idx == 3'd7);
  assign byte_val  = {in_sr, si_s};
  assign so_bit    = out_sr[7];

  // R10: bit position frozen while held
  a_r10_hold_freezes_bits: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(bit_idx));

  // R12: a frame edge realigns to bit 0
  a_r12_frame_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> (bit_idx == 3'd0));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_csfall,
  input  logic          ev_csrise,
  input  logic          byte_done,
  input  logic [7:0]    byte_val,
  input  logic          wpn_s,
  input  logic [7:0]    rd_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          tx_active,
  output logic [7:0]    tx_byte
);

  phase_t      phase;
  logic [15:0] addr;
  logic [7:0]  ahi;
  logic        is_rd;
  logic        wel;
  logic        lock;
  logic [1:0]  spare;
  logic        wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      addr    <= '0;
      ahi     <= '0;
      is_rd   <= 1'b0;
      wel     <= 1'b0;
      lock    <= 1'b0;
      spare   <= '0;
      wr_done <= 1'b0;
    end else if (ev_csfall) begin
      phase   <= PH_CMD;
      wr_done <= 1'b0;
    end else if (ev_csrise) begin
      phase   <= PH_IDLE;
      wr_done <= 1'b0;
      if (wr_done) wel <= 1'b0;
    end else if (byte_done) begin
      case (phase)
        PH_CMD: begin
          phase <= phase_for_op(byte_val);
          is_rd <= (byte_val == OP_READ);
          if (byte_val == OP_WREN) wel <= 1'b1;
          if (byte_val == OP_WRDI) wel <= 1'b0;
        end
        PH_AHI: begin
          ahi   <= byte_val;
          phase <= PH_ALO;
        end
        PH_ALO: begin
          addr  <= addr_fold({ahi, byte_val}, DEPTH);
          phase <= is_rd ? PH_RDAT : PH_WDAT;
        end
        PH_WDAT: begin
          addr    <= addr_step(addr, DEPTH);
          wr_done <= 1'b1;
        end
        PH_RDAT: addr <= addr_step(addr, DEPTH);
        PH_SRWR: begin
          if (wel && !sr_locked(wpn_s, lock)) begin
            lock  <= byte_val[7];
            spare <= byte_val[3:2];
          end
          wr_done <= 1'b1;
          phase   <= PH_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign mem_we    = byte_done && (phase == PH_WDAT) && wel;
  assign mem_addr  = addr[AW-1:0];
  assign mem_wdata = byte_val;
  assign tx_active = (phase == PH_RDAT) || (phase == PH_SRRD);
  assign tx_byte   = (phase == PH_RDAT) ? rd_data : sr_pack(lock, spare, wel);

  // R3: every new frame starts in command phase
  a_r3_frame_starts_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_csfall |=> (phase == PH_CMD));

  // R6: read address wraps from the top to zero
  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_RDAT && addr == 16'(DEPTH - 1)) |=> (addr == 16'd0));

  // R7: latch dropped when a write frame ends
  a_r7_latch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_csrise && wr_done) |=> !wel);

  // R9: locked status keeps its bits
  a_r9_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_SRWR && !wpn_s && lock) |=> ($stable(lock) && $stable(spare)));

  // R5: memory writes happen only inside the write data phase
  a_r5_write_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_WDAT && !is_rd));

endmodule

// File: rtl/spim_store.sv
module spim_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int DEPTH = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn,
  input  logic sck,
  input  logic si,
  input  logic holdn,
  input  logic wpn,
  output logic so,
  output logic so_en
);

  logic [4:0]    pins_s;
  logic          held, csn_eff, ev_rise, ev_fall, ev_csfall, ev_csrise;
  logic          byte_done, so_bit, oe_q, tx_active, mem_we;
  logic [7:0]    byte_val, tx_byte, mem_wdata, rd_data;
  logic [AW-1:0] mem_addr;

  spim_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({wpn, holdn, si, csn, sck}), .d_out(pins_s));

  spim_pinctl u_pin (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[0]), .csn_s(pins_s[1]), .holdn_s(pins_s[3]),
    .held(held), .csn_eff(csn_eff), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_csfall(ev_csfall), .ev_csrise(ev_csrise));

  spim_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .held(held),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_frame(ev_csfall || ev_csrise),
    .si_s(pins_s[2]), .tx_active(tx_active), .tx_byte(tx_byte),
    .byte_done(byte_done), .byte_val(byte_val), .so_bit(so_bit), .oe_q(oe_q));

  spim_ctrl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ev_csfall(ev_csfall), .ev_csrise(ev_csrise),
    .byte_done(byte_done), .byte_val(byte_val), .wpn_s(pins_s[4]),
    .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .tx_active(tx_active), .tx_byte(tx_byte));

  spim_store #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(rd_data));

  assign so    = so_bit;
  assign so_en = oe_q && !held;

  // R2: output released whenever deselected
  a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    csn_eff |-> !so_en);

  // R4: output driven only in a read phase
  a_r4_drive_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> tx_active);

endmodule

// File: tb/sim_spi_nvm_slave.sv
module sim_spi_nvm_slave;

  localparam int DEPTH = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, si = 1'b0, holdn = 1'b1, wpn = 1'b1;
  logic so, so_en;

  always #4 clk = ~clk;

  spi_nvm_slave u0 (.clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .si(si),
                    .holdn(holdn), .wpn(wpn), .so(so), .so_en(so_en));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] bmem [DEPTH];
  bit bwel = 0, block = 0, bwr = 0;
  bit [1:0] bspare = 0;
  logic [7:0] rxb;
  bit oe_all, stab;

  function automatic logic [7:0] exp_sr();
    return {block, 3'b000, bspare, bwel, 1'b0};
  endfunction

  function automatic int wrap_addr(input int a);
    return a % DEPTH;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bytex(input logic [7:0] tx);
    oe_all = 1; stab = 1;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      waitc(4);
      rxb[i] = so;
      oe_all &= (so_en === 1'b1);
      sck = 1'b1;
      waitc(4);
      if (so !== rxb[i]) stab = 0;
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    csn = 1'b0; waitc(4);
  endtask

  task automatic desel();
    sck = 1'b0; csn = 1'b1; waitc(4);
    if (bwr) bwel = 0;
    bwr = 0;
  endtask

  task automatic do_wren();
    sel(); bytex(8'h06); desel(); bwel = 1;
  endtask

  task automatic do_wrdi();
    sel(); bytex(8'h04); desel(); bwel = 0;
  endtask

  task automatic do_rdsr(input string req, input int n);
    sel(); bytex(8'h05);
    for (int k = 0; k < n; k++) begin
      bytex(8'h00);
      check(req, rxb, exp_sr());
    end
    desel();
  endtask

  task automatic do_wrsr(input logic [7:0] v, input logic wp);
    wpn = wp;
    sel(); bytex(8'h01); bytex(v);
    if (bwel && !(!wp && block)) begin block = v[7]; bspare = v[3:2]; end
    bwr = 1;
    desel(); wpn = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    logic [7:0] d;
    sel(); bytex(8'h02); bytex(a[15:8]); bytex(a[7:0]);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      bytex(d);
      if (bwel) bmem[wrap_addr(int'(a) + k)] = d;
      bwr = 1;
    end
    desel();
  endtask

  task automatic do_read(input string req, input logic [15:0] a, input int n);
    sel(); bytex(8'h03); bytex(a[15:8]); bytex(a[7:0]);
    for (int k = 0; k < n; k++) begin
      bytex(8'h00);
      check(req, rxb, bmem[wrap_addr(int'(a) + k)]);
      check({req, " oe/edge"}, {30'd0, oe_all, stab}, 32'd3);
    end
    desel();
    check("R2 oe after deselect", so_en, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) bmem[i] = 8'h00;
    waitc(5); rst_n = 1'b1; waitc(5);

    // R1 reset state
    check("R1 oe at reset", so_en, 1'b0);
    do_rdsr("R1 status at reset", 1);
    do_read("R1 memory at reset", 16'h0000, 2);

    // R5 write without latch is dropped
    do_write(16'h0005, 1);
    do_read("R5 no write without latch", 16'h0005, 1);

    // R7 latch visible, cleared by 0x04
    do_wren(); do_rdsr("R7 latch set", 1);
    do_wrdi(); do_rdsr("R7 latch cleared by 0x04", 1);

    // R6 wrap and address folding
    do_wren(); do_write(16'h00FE, 4);
    do_rdsr("R7 latch cleared after write", 1);
    do_read("R6 wrap read", 16'h00FE, 4);
    do_read("R6 high address bits folded", 16'h01FE, 3);

    // R8 status format, R9 protect
    do_wren(); do_wrsr(8'hFF, 1'b1); do_rdsr("R8 status bits", 2);
    do_wren(); do_wrsr(8'h00, 1'b0); do_rdsr("R9 locked write blocked", 1);
    do_wren(); do_wrsr(8'h00, 1'b1); do_rdsr("R9 unlocked by pin high", 1);

    // R2 activity while deselected
    for (int i = 7; i >= 0; i--) begin
      si = 8'h06 >> i; waitc(4); sck = 1'b1; waitc(4);
      check("R2 oe while deselected", so_en, 1'b0);
      sck = 1'b0;
    end
    do_rdsr("R2 deselected clocks ignored", 1);

    // R3 command only first byte of frame
    sel(); bytex(8'h05); bytex(8'h06); desel();
    do_rdsr("R3 later 0x06 not a command", 1);

    // R12 abort mid-byte
    do_wren();
    sel(); bytex(8'h02); bytex(8'h00); bytex(8'h10); bytex(8'hA5);
    bmem[16'h10] = 8'hA5; bwr = 1;
    for (int i = 0; i < 4; i++) begin si = 1'b1; waitc(4); sck = 1'b1; waitc(4); sck = 1'b0; end
    desel();
    do_read("R12 partial byte dropped", 16'h0010, 2);

    // R13 unknown command
    sel(); bytex(8'h9F); bytex(8'h00);
    check("R13 oe after unknown command", oe_all, 1'b0);
    desel();
    do_rdsr("R13 state unchanged", 1);

    // R10 hold in the middle of a read byte
    do_wren(); do_write(16'h0040, 2);
    sel(); bytex(8'h03); bytex(8'h00); bytex(8'h40);
    got = 8'h00;
    for (int i = 7; i >= 5; i--) begin
      si = 1'b0; waitc(4); got[i] = so; sck = 1'b1; waitc(4); sck = 1'b0;
    end
    holdn = 1'b0; waitc(4);
    check("R10 oe low while held", so_en, 1'b0);
    repeat (3) begin sck = 1'b1; waitc(4); sck = 1'b0; waitc(4); end
    csn = 1'b1; waitc(4); csn = 1'b0; waitc(4);
    check("R10 oe low while held late", so_en, 1'b0);
    holdn = 1'b1; waitc(4);
    for (int i = 4; i >= 0; i--) begin
      si = 1'b0; waitc(4); got[i] = so; sck = 1'b1; waitc(4); sck = 1'b0;
    end
    check("R10 byte resumed", got, bmem[16'h40]);
    bytex(8'h00);
    check("R10 next byte after resume", rxb, bmem[16'h41]);
    desel();

    // R11 hold pulse inside clock-high phase
    do_wren();
    sel(); bytex(8'h02); bytex(8'h00); bytex(8'h60);
    for (int i = 7; i >= 0; i--) begin
      si = 8'hC3 >> i; waitc(4); sck = 1'b1;
      if (i == 4) begin waitc(1); holdn = 1'b0; waitc(3); holdn = 1'b1; waitc(4); end
      else waitc(4);
      sck = 1'b0;
    end
    bmem[16'h60] = 8'hC3; bwr = 1;
    desel();
    do_read("R11 glitch ignored", 16'h0060, 1);

    // random mix
    for (int k = 0; k < 60; k++) begin
      case ($urandom_range(0, 5))
        0: do_wren();
        1: do_wrdi();
        2: do_rdsr("R8 random status", 1);
        3: begin do_wren(); do_wrsr(8'($urandom), 1'($urandom_range(0, 1))); end
        4: begin if ($urandom_range(0, 3) != 0) do_wren();
                 do_write(16'($urandom), $urandom_range(1, 4)); end
        default: do_read("R4 random read", 16'($urandom), $urandom_range(1, 4));
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule